// File: doc/BRIEF.md
# Atomic Bit Test-and-Modify Sequencer

This block carries out a single-bit test-and-modify on an operand for a branch-on-bit step. The operand is either a byte in memory, reached over a simple request/ready bus with a lock line, or a register value handed to the block directly. A one-cycle start strobe launches an operation. It carries a base byte address, a bit position, the value the selected bit must take, a memory-or-register flag, and an interlock flag. When the operation finishes, the block returns the bit's original value together with a one-cycle done pulse. The caller uses that value to decide whether to branch.

For a memory operand, the bit position is split into two parts. The upper bits give a byte offset that is added to the base address. The lowest three bits select a bit within that byte, with bit 0 as the least significant bit. The sequencer reads the byte, then writes it back with only the selected bit changed. When the interlock flag is set, the lock line is held from the read request until the write is acknowledged. This keeps other masters that honour the lock from running a similar locked sequence in between. The original bit is reported only after the lock has been released.

A register operand never touches the bus and never locks. Its bit position must not exceed the register width minus one. A larger position is a reserved-operand fault: no bus cycle is issued and no result is written back.

Top module: `bb_rmw_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `busy_o`, `done_o`, `bus_req_o`, `bus_we_o` and `bus_lock_o` are all low.
- R2: A memory operation reads the byte at `base_i + (pos_i >> 3)` and then writes that same byte back. Only bit `pos_i[2:0]` is replaced by `new_val_i`, and every other bit keeps its read value.
- R3: When `ilock_i` is high on a memory operation, `bus_lock_o` is high in every cycle of the read request and of the write request. It stays high from the first read cycle until the write is acknowledged.
- R4: When `ilock_i` is low, a memory operation runs the same read and write with `bus_lock_o` held low throughout.
- R5: While `bus_req_o` is high and `bus_rdy_i` is low, the request, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` hold their values. Each bus phase therefore lasts exactly one cycle more than the wait cycles the bus inserts.
- R6: `done_o` is a single-cycle pulse. For a memory operation it comes in the cycle after the write acknowledge, while `bus_lock_o` and `bus_req_o` are low. In that cycle `old_bit_o` carries the bit's value from before the operation.
- R7: A register operation (`is_mem_i` low, `pos_i` ≤ DW−1) issues no bus request and no lock. In the cycle after start it raises `done_o` and `reg_we_o`. At the same time, `reg_wdata_o` equals `reg_val_i` with bit `pos_i` replaced by `new_val_i`, and `old_bit_o` equals the original bit.
- R8: A register operation with `pos_i` > DW−1 raises `done_o` and `fault_o` in the cycle after start. It keeps `reg_we_o` low and issues no bus cycle. A memory operation never faults, whatever its position.
- R9: A start pulse is ignored while `busy_o` is high, including the done cycle. It causes no extra bus cycle, no extra done pulse and no register write.
- R10: Bit numbering is little-endian in both paths: position 0 selects the least significant bit of the byte or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle operation request, sampled when idle |
| is_mem_i | input | 1 | 1: operand is a memory byte; 0: operand is `reg_val_i` |
| ilock_i | input | 1 | Hold the bus lock across the read-modify-write (memory only) |
| base_i | input | AW | Base byte address |
| pos_i | input | POS_W | Bit position relative to the base |
| new_val_i | input | 1 | Value written into the selected bit |
| reg_val_i | input | DW | Register operand value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| old_bit_o | output | 1 | Original bit value, valid with `done_o` |
| fault_o | output | 1 | Reserved-operand fault, valid with `done_o` |
| reg_we_o | output | 1 | Register write-back strobe |
| reg_wdata_o | output | DW | Register value with the bit replaced |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_lock_o | output | 1 | Bus lock |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data |
| bus_rdy_i | input | 1 | Bus acknowledge for the current phase |

## Verification
Two functions can meet in one cycle: the sequencer's completion (the write acknowledge followed by the done pulse) and the acceptance of a new start request. The bench drives a start pulse exactly in the done cycle, and others while a waited bus phase is still pending. Each of these requests names a different register or memory operand, so any wrongly accepted request would leave a trace. The bench judges the result by counting bus transfers, done pulses and register write strobes over the following cycles, and by confirming that the untouched byte and the lock line show no extra activity.

// File: rtl/bb_rmw_pkg.sv
package bb_rmw_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_FIN   = 2'd3
    } sq_state_t;

    typedef struct packed {
        logic mem;
        logic lock;
        logic newv;
        logic fault;
    } sq_flags_t;

    function automatic logic [7:0] byte_lane_mask(input logic [2:0] sel);
        return 8'b1 << sel;
    endfunction

endpackage

// File: rtl/bb_addr_gen.sv
module bb_addr_gen #(
    parameter int AW    = 8,
    parameter int POS_W = 8,
    parameter int DW    = 32
) (
    input  logic [AW-1:0]            base,
    input  logic [POS_W-1:0]         pos,
    input  logic                     is_mem,
    output logic [AW-1:0]            eff_addr,
    output logic [2:0]               byte_bit,
    output logic [$clog2(DW)-1:0]    reg_bit,
    output logic                     fault
);
    localparam int RBW = $clog2(DW);
    localparam logic [POS_W-1:0] REG_LIMIT = POS_W'(DW - 1);

    logic [POS_W-1:0] byte_off;

    always_comb begin
        byte_off = pos >> 3;
        eff_addr = base + AW'(byte_off);
        byte_bit = pos[2:0];
        reg_bit  = pos[RBW-1:0];
        fault    = !is_mem && (pos > REG_LIMIT);
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0]          din,
    input  logic [$clog2(W)-1:0]  sel,
    input  logic                  val,
    output logic [W-1:0]          dout
);
    localparam int SW = $clog2(W);

    for (genvar i = 0; i < W; i++) begin : g_lane
        assign dout[i] = (sel == SW'(i)) ? val : din[i];
    end
endmodule

// File: rtl/bb_seq_ctrl.sv
module bb_seq_ctrl
    import bb_rmw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_mem,
    input  logic ilock,
    input  logic fault,
    input  logic rdy,
    output logic accept,
    output logic rd_ack,
    output logic busy,
    output logic done,
    output logic req,
    output logic we,
    output logic lock
);
    sq_state_t st_q, st_d;
    logic      lock_q;

    always_comb begin
        accept = (st_q == SQ_IDLE) && start;
        rd_ack = (st_q == SQ_READ) && rdy;
        st_d   = st_q;
        unique case (st_q)
            SQ_IDLE:  if (start) st_d = (fault || !is_mem) ? SQ_FIN : SQ_READ;
            SQ_READ:  if (rdy) st_d = SQ_WRITE;
            SQ_WRITE: if (rdy) st_d = SQ_FIN;
            SQ_FIN:   st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            lock_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) lock_q <= is_mem && ilock && !fault;
        end
    end

    assign busy = (st_q != SQ_IDLE);
    assign done = (st_q == SQ_FIN);
    assign req  = (st_q == SQ_READ) || (st_q == SQ_WRITE);
    assign we   = (st_q == SQ_WRITE);
    assign lock = lock_q && req;

    assert_lock_held_R3: assert property (@(posedge clk) disable iff (rst)
        (lock && !(we && rdy)) |=> lock);

    assert_req_waits_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !rdy) |=> (req && $stable(we)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!lock && !req));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !busy);
endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
    import bb_rmw_pkg::*;
#(
    parameter int AW    = 8,
    parameter int POS_W = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             is_mem_i,
    input  logic             ilock_i,
    input  logic [AW-1:0]    base_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             new_val_i,
    input  logic [DW-1:0]    reg_val_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             old_bit_o,
    output logic             fault_o,
    output logic             reg_we_o,
    output logic [DW-1:0]    reg_wdata_o,
    output logic             bus_req_o,
    output logic             bus_we_o,
    output logic             bus_lock_o,
    output logic [AW-1:0]    bus_addr_o,
    output logic [7:0]       bus_wdata_o,
    input  logic [7:0]       bus_rdata_i,
    input  logic             bus_rdy_i
);
    localparam int RBW = $clog2(DW);
    localparam logic [POS_W-1:0] REG_LIMIT = POS_W'(DW - 1);

    logic [AW-1:0]  eff_addr;
    logic [2:0]     byte_bit;
    logic [RBW-1:0] reg_bit;
    logic           fault_now;
    logic           accept, rd_ack;

    logic [AW-1:0]  addr_q;
    logic [2:0]     bsel_q;
    logic [RBW-1:0] rsel_q;
    logic [DW-1:0]  regv_q;
    logic [7:0]     rdbyte_q;
    logic           old_q;
    sq_flags_t      fl_q;

    bb_addr_gen #(.AW(AW), .POS_W(POS_W), .DW(DW)) u_agen (
        .base     (base_i),
        .pos      (pos_i),
        .is_mem   (is_mem_i),
        .eff_addr (eff_addr),
        .byte_bit (byte_bit),
        .reg_bit  (reg_bit),
        .fault    (fault_now)
    );

    bb_seq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .is_mem (is_mem_i),
        .ilock  (ilock_i),
        .fault  (fault_now),
        .rdy    (bus_rdy_i),
        .accept (accept),
        .rd_ack (rd_ack),
        .busy   (busy_o),
        .done   (done_o),
        .req    (bus_req_o),
        .we     (bus_we_o),
        .lock   (bus_lock_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            bsel_q   <= '0;
            rsel_q   <= '0;
            regv_q   <= '0;
            rdbyte_q <= '0;
            old_q    <= 1'b0;
            fl_q     <= '0;
        end else begin
            if (accept) begin
                addr_q     <= eff_addr;
                bsel_q     <= byte_bit;
                rsel_q     <= reg_bit;
                regv_q     <= reg_val_i;
                fl_q.mem   <= is_mem_i;
                fl_q.lock  <= ilock_i;
                fl_q.newv  <= new_val_i;
                fl_q.fault <= fault_now;
                old_q      <= (!is_mem_i && !fault_now) ? reg_val_i[reg_bit] : 1'b0;
            end
            if (rd_ack) begin
                rdbyte_q <= bus_rdata_i;
                old_q    <= bus_rdata_i[bsel_q];
            end
        end
    end

    bb_bit_merge #(.W(8)) u_bmerge (
        .din  (rdbyte_q),
        .sel  (bsel_q),
        .val  (fl_q.newv),
        .dout (bus_wdata_o)
    );

    bb_bit_merge #(.W(DW)) u_rmerge (
        .din  (regv_q),
        .sel  (rsel_q),
        .val  (fl_q.newv),
        .dout (reg_wdata_o)
    );

    assign bus_addr_o = addr_q;
    assign old_bit_o  = done_o && old_q;
    assign fault_o    = done_o && fl_q.fault;
    assign reg_we_o   = done_o && !fl_q.mem && !fl_q.fault;

    logic [7:0] keep_mask;
    assign keep_mask = ~byte_lane_mask(bsel_q);

    assert_keep_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_we_o && bus_rdy_i) |=>
        ((bus_wdata_o & keep_mask) == ($past(bus_rdata_i) & keep_mask)));

    assert_hold_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_rdy_i) |=>
        ($stable(bus_addr_o) && $stable(bus_wdata_o)));

    assert_reg_path_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !is_mem_i && (pos_i <= REG_LIMIT)) |=>
        (reg_we_o && done_o && !bus_req_o && !bus_lock_o));

    assert_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !is_mem_i && (pos_i > REG_LIMIT)) |=>
        (fault_o && !reg_we_o && !bus_req_o));

    assert_no_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !ilock_i) |=> !bus_lock_o);
endmodule

// File: tb/sim_bb_rmw_seq.sv
module sim_bb_rmw_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, is_mem_i = 0, ilock_i = 0, new_val_i = 0;
    logic [7:0]  base_i = 0, pos_i = 0;
    logic [31:0] reg_val_i = 0;
    logic        busy_o, done_o, old_bit_o, fault_o, reg_we_o;
    logic [31:0] reg_wdata_o;
    logic        bus_req_o, bus_we_o, bus_lock_o;
    logic [7:0]  bus_addr_o, bus_wdata_o;
    logic [7:0]  bus_rdata_i = 0;
    logic        bus_rdy_i = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_rmw_seq u0 (.*);

    int tests = 0, fails = 0;
    logic [7:0] mem [256];
    int wait_n = 0, cnt = 0;
    int n_xfer = 0, n_lock = 0, n_done = 0, n_we = 0;
    logic rd_lk = 0, wr_lk = 0;
    logic p_req = 0, p_we = 0, p_rdy = 0, p_lk = 0;
    logic [7:0] p_addr = 0, p_wd = 0;

    always @(negedge clk) begin
        if (rst) begin
            cnt = 0; p_req = 0; p_rdy = 0; bus_rdy_i = 0;
        end else begin
            if (p_req && p_rdy) begin
                if (p_we) begin mem[p_addr] = p_wd; wr_lk = p_lk; end
                else rd_lk = p_lk;
                n_xfer++;
                cnt = 0;
            end else if (p_req) cnt++;
            if (bus_lock_o) n_lock++;
            if (done_o) n_done++;
            if (reg_we_o) n_we++;
            bus_rdy_i   = bus_req_o && (cnt >= wait_n);
            bus_rdata_i = mem[bus_addr_o];
            p_req = bus_req_o; p_we = bus_we_o; p_rdy = bus_rdy_i;
            p_addr = bus_addr_o; p_wd = bus_wdata_o; p_lk = bus_lock_o;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog expired act=%0d exp<20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic        g_old, g_flt, g_we, g_lk;
    logic [31:0] g_wd;
    int          g_k, x0, l0, d0, w0;

    task automatic run_op(input logic m, input logic lk, input logic [7:0] b,
                          input logic [7:0] p, input logic nv, input logic [31:0] rv);
        @(negedge clk);
        x0 = n_xfer; l0 = n_lock; d0 = n_done; w0 = n_we;
        is_mem_i = m; ilock_i = lk; base_i = b; pos_i = p; new_val_i = nv;
        reg_val_i = rv; start_i = 1;
        @(negedge clk);
        start_i = 0;
        g_k = 1;
        while (!done_o && g_k < 100) begin @(negedge clk); g_k++; end
        g_old = old_bit_o; g_flt = fault_o; g_we = reg_we_o;
        g_wd = reg_wdata_o; g_lk = bus_lock_o | bus_req_o;
        @(negedge clk);
        chk("R6 done is single pulse", {31'b0, done_o}, 0);
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", {31'b0, busy_o}, 0);
        chk("R1 req after reset", {31'b0, bus_req_o}, 0);
        chk("R1 lock after reset", {31'b0, bus_lock_o}, 0);
        chk("R1 done after reset", {31'b0, done_o}, 0);
        chk("R1 we after reset", {31'b0, bus_we_o}, 0);
    endtask

    task automatic t_mem_locked;
        wait_n = 0; mem[5] = 8'hA5;
        run_op(1, 1, 8'h03, 8'd17, 1, 0);
        chk("R2 R10 byte written", mem[5], 8'hA7);
        chk("R6 old bit", g_old, 0);
        chk("R2 two transfers", n_xfer - x0, 2);
        chk("R3 lock on read", rd_lk, 1);
        chk("R3 lock on write", wr_lk, 1);
        chk("R3 lock cycles", n_lock - l0, 2);
        chk("R6 bus idle at done", g_lk, 0);
        chk("R6 latency", g_k, 3);
        wait_n = 2; mem[8'h20] = 8'h00;
        run_op(1, 1, 8'h1E, 8'd22, 1, 0);
        chk("R2 bit6 set", mem[8'h20], 8'h40);
        chk("R3 lock cycles waited", n_lock - l0, 6);
        chk("R5 latency waited", g_k, 7);
        chk("R3 lock on write waited", wr_lk, 1);
    endtask

    task automatic t_mem_plain;
        wait_n = 3; mem[9] = 8'hFF;
        run_op(1, 0, 8'h09, 8'd7, 0, 0);
        chk("R4 byte written", mem[9], 8'h7F);
        chk("R6 old bit set", g_old, 1);
        chk("R4 no lock", n_lock - l0, 0);
        chk("R5 latency wait3", g_k, 9);
        chk("R4 transfers", n_xfer - x0, 2);
        wait_n = 0; mem[8'h29] = 8'h80;
        run_op(1, 0, 8'h10, 8'd200, 1, 0);
        chk("R8 mem high pos no fault", g_flt, 0);
        chk("R2 far byte", mem[8'h29], 8'h81);
    endtask

    task automatic t_register;
        run_op(0, 1, 8'h00, 8'd31, 1, 32'h0000_0001);
        chk("R7 wdata pos31", g_wd, 32'h8000_0001);
        chk("R7 we", g_we, 1);
        chk("R7 old", g_old, 0);
        chk("R7 no bus", n_xfer - x0, 0);
        chk("R7 no lock", n_lock - l0, 0);
        chk("R7 latency", g_k, 1);
        run_op(0, 0, 8'h00, 8'd0, 0, 32'hFFFF_FFFF);
        chk("R10 R7 wdata pos0", g_wd, 32'hFFFF_FFFE);
        chk("R7 old set", g_old, 1);
    endtask

    task automatic t_fault;
        run_op(0, 1, 8'h00, 8'd32, 1, 32'h1234);
        chk("R8 fault", g_flt, 1);
        chk("R8 no write", g_we, 0);
        chk("R8 no bus", n_xfer - x0, 0);
        chk("R8 no we pulse", n_we - w0, 0);
        chk("R8 latency", g_k, 1);
    endtask

    task automatic t_busy;
        int k;
        wait_n = 4; mem[8'h40] = 8'h0F; mem[8'h50] = 8'h00;
        @(negedge clk);
        x0 = n_xfer; d0 = n_done; w0 = n_we; l0 = n_lock;
        is_mem_i = 1; ilock_i = 1; base_i = 8'h40; pos_i = 8'd4; new_val_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        is_mem_i = 0; pos_i = 8'd3; reg_val_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        k = 0;
        while (!done_o && k < 100) begin @(negedge clk); k++; end
        is_mem_i = 1; ilock_i = 1; base_i = 8'h50; pos_i = 8'd0; new_val_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (6) @(negedge clk);
        chk("R9 only two transfers", n_xfer - x0, 2);
        chk("R9 one done", n_done - d0, 1);
        chk("R9 no reg write", n_we - w0, 0);
        chk("R9 other byte untouched", mem[8'h50], 8'h00);
        chk("R9 target byte", mem[8'h40], 8'h1F);
        chk("R9 idle after", {31'b0, busy_o}, 0);
        chk("R3 lock cycles busy test", n_lock - l0, 10);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3);
        repeat (4) @(negedge clk);
        t_reset();
        rst = 0;
        t_mem_locked();
        t_mem_plain();
        t_register();
        t_fault();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule